// File: doc/BRIEF.md
# Five-Channel Output Compare Unit with Forced Compares

This block compares a 16-bit free-running counter against five compare registers, one for each channel. When the counter equals a channel's compare value on a counter tick, that channel performs its configured pin action and latches a status flag. Software can also push any subset of channels through their pin actions early by writing a strobe register. A forced action changes the pins exactly as a match would. It does not raise a status flag, and it waits for the next counter tick after the write.

Channels 2 to 5 each own one output pin. For each of them a two-bit code picks one of four pin actions: none, toggle, drive low or drive high. Channel 1 can drive any of the five pins. A mask register selects which pins it controls, and a data register gives the level each masked pin is loaded with. The unit is programmed through a byte-wide register bus with an address, a write strobe and combinational read data. The counter advances only on cycles where the `tick` input is high.

Top module: `outcmp_unit`

## Requirements
- R1: The counter resets to 0. It adds 1 on every clock edge with `tick` high, wraps from 0xFFFF to 0, and holds its value when `tick` is low. The high byte reads at address 0x05 and the low byte at address 0x06.
- R2: Channel k (k = 1..5) uses bit position 8-k in the force, flag, mask and data registers, so channel 1 is bit 7 and channel 5 is bit 3. Its compare value has the high byte at address 0x08+2(k-1) and the low byte at the address one above. Compare values reset to 0xFFFF. A match is a clock edge where `tick` is high and the counter equals the compare value. A match applies the channel's pin action at that same edge and sets its flag.
- R3: The action register at address 0x03 holds a two-bit code for each of channels 2, 3, 4 and 5, in bits [7:6], [5:4], [3:2] and [1:0] respectively. The codes are 00 no action, 01 toggle, 10 drive low and 11 drive high. Channel k (k >= 2) drives pin 8-k.
- R4: When channel 1 acts, each pin p whose bit is set in the mask register (address 0x01) is loaded from bit p of the data register (address 0x02). Both registers keep bits 7:3 only, read 0 in bits 2:0, and reset to 0.
- R5: When channel 1 and channel k act in the same tick, and channel 1 has pin 8-k in its mask, channel 1's value wins on that pin.
- R6: Writing 1 to a bit of the force register (address 0x00) makes that channel act at the next tick edge after the write cycle. A tick in the write cycle itself does not count. A forced action never sets a flag. Writing 0 to a bit has no effect.
- R7: The force register always reads 0.
- R8: The flag register is at address 0x04 and its bits 7:3 are on `flag_o`. A flag is cleared by writing 1 to its bit. If a match and a clear fall in the same cycle, the flag stays set.
- R9: Pins reset to 0 and change only on clock edges where `tick` is high. Pins read back at address 0x07, bits 7:3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Counter advance enable |
| we | input | 1 | Register write strobe |
| addr | input | 5 | Register address for read and write |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data for `addr` |
| count_o | output | 16 | Free-running counter value |
| pin_o | output | 5 | Output pins 7 down to 3 |
| flag_o | output | 5 | Status flags of channels 1 to 5 (bits 7 down to 3) |

## Verification
A corrupted compare register or a stale pending force shows up on `pin_o` at the first tick edge where the channel should or should not act. A wrong flag update is visible on `flag_o` in the same cycle. Counter faults appear on `count_o` one edge after the tick that causes them. The bench keeps a full reference model of every register and checks the counter, pins and flags after every clock edge. It also checks read data after each directed step, so any divergence is reported within one cycle of where it arises.

// File: rtl/outcmp_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and the pin-action encoding of the output-compare unit.
// Assumes an 8-bit register bus and a counter two bus bytes wide.
package outcmp_pkg;
    localparam int DATA_W  = 8;
    localparam int CNT_W   = 2 * DATA_W;
    localparam int ADDR_W  = 5;
    localparam int CH_LO   = 3;            // lowest channel bit position (channel 5)
    localparam int CH_HI   = 7;            // highest channel bit position (channel 1)

    localparam logic [ADDR_W-1:0] A_FORCE  = 5'h00;
    localparam logic [ADDR_W-1:0] A_MASK   = 5'h01;
    localparam logic [ADDR_W-1:0] A_DATA   = 5'h02;
    localparam logic [ADDR_W-1:0] A_ACTION = 5'h03;
    localparam logic [ADDR_W-1:0] A_FLAG   = 5'h04;
    localparam logic [ADDR_W-1:0] A_CNT_HI = 5'h05;
    localparam logic [ADDR_W-1:0] A_CNT_LO = 5'h06;
    localparam logic [ADDR_W-1:0] A_PINS   = 5'h07;
    localparam logic [ADDR_W-1:0] A_CMP0   = 5'h08;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'b00,
        ACT_TOGGLE = 2'b01,
        ACT_LOW    = 2'b10,
        ACT_HIGH   = 2'b11
    } pin_act_e;

    // Address of the compare high byte for the channel at bit position pos.
    function automatic logic [ADDR_W-1:0] cmp_hi_addr(input int pos);
        return A_CMP0 + ADDR_W'(2 * (CH_HI - pos));
    endfunction
endpackage

// File: rtl/outcmp_counter.sv
`timescale 1ns/1ps
// Free-running up counter. It advances by one on each enabled clock and wraps
// naturally at its width. Assumes a synchronous active-low reset.
module outcmp_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    output logic [CNT_W-1:0] count
);
    // Count up on each tick, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (tick)
            count <= count + 1'b1;
    end
endmodule

// File: rtl/outcmp_channel.sv
`timescale 1ns/1ps
// One compare channel: it holds a byte-writable compare value and reports a
// genuine match and an action (match or due force) on tick cycles.
// Assumes the compare value is two bus bytes wide.
module outcmp_channel #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hi,
    input  logic              wr_lo,
    input  logic [DATA_W-1:0] wdata,
    input  logic              tick,
    input  logic [CNT_W-1:0]  count,
    input  logic              force_due,
    output logic [CNT_W-1:0]  cmp,
    output logic              hit,
    output logic              act
);
    // Byte-wise update of the compare value; resets to all ones.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cmp <= '1;
        else begin
            if (wr_hi) cmp[CNT_W-1:DATA_W] <= wdata;
            if (wr_lo) cmp[DATA_W-1:0]     <= wdata;
        end
    end

    // A match counts only on a tick; a pending force joins it on the same tick.
    always_comb begin
        hit = tick && (count == cmp);
        act = hit || (tick && force_due);
    end
endmodule

// File: rtl/outcmp_pins.sv
`timescale 1ns/1ps
// Output pin register. Channel 1 (bit CH_HI) loads its masked pins from its data
// register and wins over the single-pin channels. Each other channel applies its
// two-bit action to its own pin. Assumes act is only set on tick cycles.
module outcmp_pins
    import outcmp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CH_HI:CH_LO] act,
    input  logic [CH_HI:CH_LO] mask,
    input  logic [CH_HI:CH_LO] data1,
    input  logic [DATA_W-1:0]  action,
    output logic [CH_HI:CH_LO] pins
);
    logic [CH_HI:CH_LO] pins_nx;

    // Work out the next pin levels from the single-pin channels, then channel 1.
    always_comb begin
        pins_nx = pins;
        for (int p = CH_LO; p < CH_HI; p++) begin
            if (act[p]) begin
                case (pin_act_e'(action[2*(p-CH_LO) +: 2]))
                    ACT_TOGGLE: pins_nx[p] = ~pins[p];
                    ACT_LOW:    pins_nx[p] = 1'b0;
                    ACT_HIGH:   pins_nx[p] = 1'b1;
                    default:    pins_nx[p] = pins[p];
                endcase
            end
        end
        for (int p = CH_LO; p <= CH_HI; p++) begin
            if (act[CH_HI] && mask[p])
                pins_nx[p] = data1[p];
        end
    end

    // Register the pin levels.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pins <= '0;
        else
            pins <= pins_nx;
    end
endmodule

// File: rtl/outcmp_unit.sv
`timescale 1ns/1ps
// Five-channel output-compare unit with forced compares. It holds the register
// bank, the pending-force strobes and the flags, and instantiates the counter,
// the channels and the pin register. Assumes a single-cycle byte bus with
// combinational read data.
module outcmp_unit
    import outcmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [CNT_W-1:0]  count_o,
    output logic [CH_HI:CH_LO] pin_o,
    output logic [CH_HI:CH_LO] flag_o
);
    localparam int LOW_W = CH_LO;    // unimplemented low bits of the bank registers

    logic [CH_HI:CH_LO] force_pend, mask_q, data_q, flag_q;
    logic [CH_HI:CH_LO] hit_vec, act_vec, clr_vec, wr_bits;
    logic [DATA_W-1:0]  action_q;
    logic [CNT_W-1:0]   cmp_val [CH_LO:CH_HI];

    assign wr_bits = wdata[CH_HI:CH_LO];

    outcmp_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .count(count_o)
    );

    for (genvar g = CH_LO; g <= CH_HI; g++) begin : g_ch
        localparam logic [ADDR_W-1:0] HI_A = cmp_hi_addr(g);
        outcmp_channel #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_ch (
            .clk(clk), .rst_n(rst_n),
            .wr_hi(we && addr == HI_A),
            .wr_lo(we && addr == HI_A + 1'b1),
            .wdata(wdata), .tick(tick), .count(count_o),
            .force_due(force_pend[g]),
            .cmp(cmp_val[g]), .hit(hit_vec[g]), .act(act_vec[g])
        );
    end

    outcmp_pins u_pins (
        .clk(clk), .rst_n(rst_n), .act(act_vec), .mask(mask_q),
        .data1(data_q), .action(action_q), .pins(pin_o)
    );

    // Pending forces: consumed by a tick, and a write in a tick cycle waits for the next one.
    always_ff @(posedge clk) begin
        if (!rst_n)
            force_pend <= '0;
        else
            force_pend <= (tick ? '0 : force_pend)
                        | ((we && addr == A_FORCE) ? wr_bits : '0);
    end

    // Configuration registers: mask, channel-1 data and action codes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q   <= '0;
            data_q   <= '0;
            action_q <= '0;
        end else if (we) begin
            if (addr == A_MASK)   mask_q   <= wr_bits;
            if (addr == A_DATA)   data_q   <= wr_bits;
            if (addr == A_ACTION) action_q <= wdata;
        end
    end

    assign clr_vec = (we && addr == A_FLAG) ? wr_bits : '0;

    // Flags: set by genuine matches only, cleared by a write of one; set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= '0;
        else
            flag_q <= (flag_q & ~clr_vec) | hit_vec;
    end

    assign flag_o = flag_q;

    // Read multiplexer over the register map.
    always_comb begin
        rdata = '0;
        case (addr)
            A_FORCE:  rdata = '0;
            A_MASK:   rdata = {mask_q, LOW_W'(0)};
            A_DATA:   rdata = {data_q, LOW_W'(0)};
            A_ACTION: rdata = action_q;
            A_FLAG:   rdata = {flag_q, LOW_W'(0)};
            A_CNT_HI: rdata = count_o[CNT_W-1:DATA_W];
            A_CNT_LO: rdata = count_o[DATA_W-1:0];
            A_PINS:   rdata = {pin_o, LOW_W'(0)};
            default: begin
                for (int g = CH_LO; g <= CH_HI; g++) begin
                    if (addr == cmp_hi_addr(g))
                        rdata = cmp_val[g][CNT_W-1:DATA_W];
                    if (addr == cmp_hi_addr(g) + 1'b1)
                        rdata = cmp_val[g][DATA_W-1:0];
                end
            end
        endcase
    end
endmodule

// File: rtl/outcmp_unit_chk.sv
`timescale 1ns/1ps
// Checker for the output-compare unit: counter stepping, pin stability, flag
// sources, flag set-wins behaviour and read-back of unimplemented bits.
// Assumes it is bound into outcmp_unit.
module outcmp_unit_chk
    import outcmp_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               tick,
    input logic [ADDR_W-1:0]  addr,
    input logic [DATA_W-1:0]  rdata,
    input logic [CNT_W-1:0]   count_o,
    input logic [CH_HI:CH_LO] pin_o,
    input logic [CH_HI:CH_LO] flag_o,
    input logic [CH_HI:CH_LO] hit_vec
);
    a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> count_o == CNT_W'($past(count_o) + 1'b1));

    a_r1_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(count_o));

    a_r9_pins_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(pin_o));

    a_r6_flag_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o & ~$past(flag_o) & ~$past(hit_vec)) == '0);

    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit_vec) |=> ((flag_o & $past(hit_vec)) == $past(hit_vec)));

    a_r7_force_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == A_FORCE) |-> rdata == '0);

    a_r4_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == A_MASK || addr == A_DATA || addr == A_FLAG) |-> rdata[CH_LO-1:0] == '0);
endmodule

bind outcmp_unit outcmp_unit_chk u_outcmp_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .addr(addr), .rdata(rdata),
    .count_o(count_o), .pin_o(pin_o), .flag_o(flag_o), .hit_vec(hit_vec)
);

// File: tb/test_outcmp_unit.sv
`timescale 1ns/1ps
module test_outcmp_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        we = 1'b0;
    logic [4:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [15:0] count_o;
    logic [7:3]  pin_o;
    logic [7:3]  flag_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    outcmp_unit i_outcmp_unit (
        .clk(clk), .rst_n(rst_n), .tick(tick), .we(we), .addr(addr),
        .wdata(wdata), .rdata(rdata), .count_o(count_o), .pin_o(pin_o), .flag_o(flag_o)
    );

    always #4 clk = ~clk;   // 125 MHz

    // Reference state, derived from the requirements.
    logic [15:0] m_cnt;
    logic [15:0] m_cmp [3:7];
    logic [7:0]  m_mask, m_data, m_act, m_flag, m_pins, m_pend;

    function automatic logic [4:0] cmp_addr(input int pos);
        return 5'(8 + 2 * (7 - pos));
    endfunction

    task automatic model_reset();
        m_cnt = 0; m_mask = 0; m_data = 0; m_act = 0; m_flag = 0; m_pins = 0; m_pend = 0;
        for (int g = 3; g <= 7; g++) m_cmp[g] = 16'hFFFF;
    endtask

    task automatic model_step(input bit tk, input bit w, input logic [4:0] a, input logic [7:0] d);
        logic [7:0] hits, acts, np, clr;
        hits = 0;
        if (tk) for (int g = 3; g <= 7; g++) hits[g] = (m_cnt == m_cmp[g]);
        acts = tk ? (hits | m_pend) : 8'h00;
        np = m_pins;
        for (int g = 3; g <= 6; g++) begin
            if (acts[g]) case (m_act[2*(g-3) +: 2])
                2'b01: np[g] = ~m_pins[g];
                2'b10: np[g] = 1'b0;
                2'b11: np[g] = 1'b1;
                default: ;
            endcase
        end
        for (int g = 3; g <= 7; g++) if (acts[7] && m_mask[g]) np[g] = m_data[g];
        clr = (w && a == 5'h04) ? (d & 8'hF8) : 8'h00;
        m_flag = (m_flag & ~clr) | hits;
        m_pend = (tk ? 8'h00 : m_pend) | ((w && a == 5'h00) ? (d & 8'hF8) : 8'h00);
        if (w) begin
            if (a == 5'h01) m_mask = d & 8'hF8;
            if (a == 5'h02) m_data = d & 8'hF8;
            if (a == 5'h03) m_act = d;
            for (int g = 3; g <= 7; g++) begin
                if (a == cmp_addr(g))      m_cmp[g][15:8] = d;
                if (a == cmp_addr(g) + 1)  m_cmp[g][7:0]  = d;
            end
        end
        m_pins = np;
        if (tk) m_cnt = m_cnt + 1;
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        check({tag, " R1 count"}, 32'(count_o), 32'(m_cnt));
        check({tag, " R9 pins"},  32'(pin_o),   32'(m_pins[7:3]));
        check({tag, " R8 flags"}, 32'(flag_o),  32'(m_flag[7:3]));
    endtask

    task automatic cyc(input bit tk, input bit w, input logic [4:0] a, input logic [7:0] d, input bit chk);
        @(negedge clk);
        tick = tk; we = w; addr = a; wdata = d;
        model_step(tk, w, a, d);
        @(posedge clk);
        #1;
        if (chk) compare_all("model");
    endtask

    task automatic rd_check(input logic [4:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        tick = 0; we = 0; addr = a; wdata = 0;
        #1;
        check(tag, 32'(rdata), 32'(exp));
        model_step(0, 0, a, 0);
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (5) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        // Reset state
        check("R1 reset count", 32'(count_o), 0);
        check("R9 reset pins", 32'(pin_o), 0);
        check("R8 reset flags", 32'(flag_o), 0);
        rd_check(5'h08, 8'hFF, "R2 compare reset hi");
        rd_check(5'h09, 8'hFF, "R2 compare reset lo");
        rd_check(5'h00, 8'h00, "R7 force read at reset");
        rd_check(5'h01, 8'h00, "R4 mask reset");

        // R1: counting and holding
        repeat (3) cyc(1, 0, 0, 0, 1);
        check("R1 three ticks", 32'(count_o), 3);
        repeat (2) cyc(0, 0, 0, 0, 1);
        check("R1 hold", 32'(count_o), 3);
        rd_check(5'h06, 8'h03, "R1 count lo read");
        rd_check(5'h05, 8'h00, "R1 count hi read");

        // R3/R2: channel 2 toggles on a match at count 6
        cyc(0, 1, 5'h03, 8'b01_10_11_01, 1);
        cyc(0, 1, cmp_addr(6), 8'h00, 1);
        cyc(0, 1, cmp_addr(6) + 5'd1, 8'h06, 1);
        repeat (4) cyc(1, 0, 0, 0, 1);
        check("R3 ch2 toggled pin6", 32'(pin_o[6]), 1);
        check("R2 ch2 flag set", 32'(flag_o[6]), 1);
        rd_check(5'h07, 8'h40, "R9 pins read");

        // R8: clear, then set and clear in the same cycle
        cyc(0, 1, 5'h04, 8'h40, 1);
        check("R8 flag cleared", 32'(flag_o[6]), 0);
        cyc(0, 1, cmp_addr(3), 8'h00, 1);
        cyc(0, 1, cmp_addr(3) + 5'd1, 8'h07, 1);
        cyc(1, 1, 5'h04, 8'h08, 1);
        check("R8 set wins over clear", 32'(flag_o[3]), 1);
        check("R3 ch5 toggled pin3", 32'(pin_o[3]), 1);

        // R6: force waits for a tick, sets no flag
        cyc(0, 1, 5'h00, 8'h10, 1);
        check("R6 no action in write cycle", 32'(pin_o[4]), 0);
        cyc(1, 0, 0, 0, 1);
        check("R6 forced drive high", 32'(pin_o[4]), 1);
        check("R6 no flag from force", 32'(flag_o[4]), 0);
        cyc(0, 1, 5'h03, 8'b01_10_10_01, 1);
        cyc(1, 1, 5'h00, 8'h10, 1);
        check("R6 tick in write cycle ignored", 32'(pin_o[4]), 1);
        cyc(1, 0, 0, 0, 1);
        check("R6 forced drive low next tick", 32'(pin_o[4]), 0);
        cyc(0, 1, 5'h00, 8'h00, 1);
        cyc(1, 0, 0, 0, 1);
        check("R6 zero write no action", 32'(pin_o), 32'(m_pins[7:3]));

        // R5: channel 1 wins over channel 2 on pin 6
        cyc(0, 1, 5'h01, 8'h40, 1);
        cyc(0, 1, 5'h02, 8'h00, 1);
        cyc(0, 1, 5'h03, 8'b11_10_10_01, 1);
        cyc(0, 1, 5'h00, 8'hC0, 1);
        cyc(1, 0, 0, 0, 1);
        check("R5 channel 1 priority", 32'(pin_o[6]), 0);
        check("R6 no flag on ch1 force", 32'(flag_o[7]), 0);

        // R4: all pins loaded from data
        cyc(0, 1, 5'h01, 8'hFF, 1);
        cyc(0, 1, 5'h02, 8'hFF, 1);
        rd_check(5'h01, 8'hF8, "R4 mask low bits read zero");
        rd_check(5'h02, 8'hF8, "R4 data low bits read zero");
        cyc(0, 1, 5'h00, 8'h80, 1);
        cyc(1, 0, 0, 0, 1);
        check("R4 masked pins loaded", 32'(pin_o), 32'h1F);
        cyc(0, 1, 5'h00, 8'hFF, 1);
        rd_check(5'h00, 8'h00, "R7 force reads zero after write");
        cyc(1, 0, 0, 0, 1);

        // Random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            int kind;
            bit tk;
            int pos;
            kind = $urandom % 10;
            tk = 1'($urandom % 2);
            pos = 3 + ($urandom % 5);
            case (kind)
                0: cyc(tk, 1, cmp_addr(pos) + 5'd1, 8'(m_cnt[7:0] + ($urandom % 6)), 1);
                1: cyc(tk, 1, cmp_addr(pos), m_cnt[15:8], 1);
                2: cyc(tk, 1, 5'h03, 8'($urandom), 1);
                3: cyc(tk, 1, 5'h01, 8'($urandom), 1);
                4: cyc(tk, 1, 5'h02, 8'($urandom), 1);
                5: cyc(tk, 1, 5'h00, 8'($urandom), 1);
                6: cyc(tk, 1, 5'h04, 8'($urandom), 1);
                default: cyc(tk, 0, 5'($urandom), 8'($urandom), 1);
            endcase
        end

        // R1: wrap from 0xFFFF to 0
        while (m_cnt != 16'hFFFF) cyc(1, 0, 0, 0, 0);
        compare_all("pre-wrap");
        cyc(1, 0, 0, 0, 1);
        check("R1 wrap to zero", 32'(count_o), 0);

        finish_run();
    end
endmodule